// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block steers accesses in the address space below 1 MB. The range from 0xC0000 to 0xFFFFF is split into thirteen regions: twelve 16 KB segments and one 64 KB top segment. Each region has a 2-bit attribute. The attribute sends the access to DRAM read-write, sends it to DRAM read-only, or forwards it to the PCI bus.

The 128 KB window at 0xA0000–0xBFFFF holds system-management memory. It opens to DRAM when the processor is in management mode and a mode-gated enable bit is set. It also opens when a force-open bit is set.

Software programs the block through a byte-wide write port. The attribute bytes and the window control byte live at fixed configuration offsets. The decode is combinational: each access address produces a target select and a write-blocked flag in the same cycle.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset every attribute field is 0, so all thirteen regions forward to PCI. The window control byte resets to 0x02, so the window goes to PCI even when `smm_active` is 1.
- R2: The 64 KB region 0xF0000–0xFFFFF takes its attribute from bits 5:4 of the byte at offset 0x59.
- R3: The 16 KB region i (i = 0..11) starts at 0xC0000 + i·0x4000. Its attribute is in the byte at offset 0x5A + i/2: bits 1:0 when i is even, bits 5:4 when i is odd.
- R4: Attribute code 3 sends reads and writes to DRAM (`to_dram`=1) with `wr_blocked`=0.
- R5: Attribute code 1 sends accesses to DRAM. For writes, `wr_blocked`=1. For reads, `wr_blocked`=0.
- R6: Attribute codes 0 and 2 give `to_dram`=0 and `wr_blocked`=0.
- R7: The window 0xA0000–0xBFFFF gives `to_dram`=1 exactly when (`smm_active` AND bit 3 of the byte at 0x72) OR bit 6 of that byte. It never blocks writes.
- R8: A change of `smm_active` changes the window decision in the same cycle, without waiting for a clock edge.
- R9: Addresses below 0xA0000, and addresses from 0x100000 up to DRAM_TOP−1, go to DRAM. Addresses at or above DRAM_TOP go to PCI. No address outside the legacy range blocks writes.
- R10: Writes to offsets other than 0x59–0x5F and 0x72 (for example 0x58, 0x60, 0x71) leave every decode unchanged.
- R11: A register write presented at a rising edge changes the decode from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| smm_active | input | 1 | Processor is in management mode |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| to_dram | output | 1 | 1 = DRAM target, 0 = PCI target |
| wr_blocked | output | 1 | Write must be discarded (read-only DRAM region) |

## Verification
The checker enforces these properties on every cycle:
- a blocked write always targets DRAM and is always a write;
- PCI-bound accesses are never blocked;
- low addresses always go to DRAM and addresses above the top of DRAM always go to PCI;
- the window decision stays steady while its address, the mode input and the registers are steady.

Only the bench scenarios can show the following:
- the exact byte-and-field placement of each region's attribute;
- the meaning of each code;
- the reset contents;
- that writes to neighbouring offsets are ignored;
- that the window opens for each combination of mode and control bits.

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DRAM_TOP = ADDR_W'(32'h0800_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              to_dram,
  output logic              wr_blocked
);
  localparam int          ATTR_BYTES = 7;
  localparam logic [7:0]  ATTR_BASE  = 8'h59;
  localparam logic [7:0]  ATTR_LAST  = ATTR_BASE + 8'(ATTR_BYTES - 1);
  localparam logic [7:0]  SMR_REG    = 8'h72;
  localparam logic [7:0]  SMR_RST    = 8'h02;
  localparam logic [ADDR_W-1:0] SMR_LO  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] SEG_LO  = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] TOP_LO  = ADDR_W'(32'h000F_0000);
  localparam logic [ADDR_W-1:0] LEG_END = ADDR_W'(32'h0010_0000);

  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] smr_q;

  wire       attr_hit = cfg_we && (cfg_addr >= ATTR_BASE) && (cfg_addr <= ATTR_LAST);
  wire [7:0] attr_off = cfg_addr - ATTR_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ATTR_BYTES; k++) attr_q[k] <= 8'h00;
      smr_q <= SMR_RST;
    end else begin
      if (attr_hit) attr_q[attr_off[2:0]] <= cfg_wdata;
      if (cfg_we && cfg_addr == SMR_REG) smr_q <= cfg_wdata;
    end
  end

  wire in_smr = (acc_addr >= SMR_LO) && (acc_addr < SEG_LO);
  wire in_seg = (acc_addr >= SEG_LO) && (acc_addr < TOP_LO);
  wire in_top = (acc_addr >= TOP_LO) && (acc_addr < LEG_END);

  wire [3:0] seg_idx  = acc_addr[17:14];
  wire [2:0] seg_byte = 3'(seg_idx[3:1]) + 3'd1;

  logic [7:0] seg_reg;
  logic [1:0] attr;
  always_comb begin
    seg_reg = attr_q[seg_byte];
    if (in_top)          attr = attr_q[0][5:4];
    else if (seg_idx[0]) attr = seg_reg[5:4];
    else                 attr = seg_reg[1:0];
  end

  wire smr_open = (smm_active && smr_q[3]) || smr_q[6];

  always_comb begin
    wr_blocked = 1'b0;
    if (in_top || in_seg) begin
      to_dram    = attr[0];
      wr_blocked = acc_write && (attr == 2'd1);
    end else if (in_smr) begin
      to_dram = smr_open;
    end else begin
      to_dram = acc_addr < DRAM_TOP;
    end
  end
endmodule

// File: rtl/legacy_region_decoder_chk.sv
module legacy_region_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DRAM_TOP = ADDR_W'(32'h0800_0000)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              smm_active,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              to_dram,
  input logic              wr_blocked
);
  localparam logic [ADDR_W-1:0] SMR_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] SEG_LO = ADDR_W'(32'h000C_0000);

  wire in_win = (acc_addr >= SMR_LO) && (acc_addr < SEG_LO);

  AST_BLOCK_ON_DRAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> (to_dram && acc_write)); // R5
  AST_PCI_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !to_dram |-> !wr_blocked); // R6
  AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr < SMR_LO) |-> (to_dram && !wr_blocked)); // R9
  AST_HIGH_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= DRAM_TOP) |-> (!to_dram && !wr_blocked)); // R9
  AST_WIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && $stable(acc_addr) && $stable(smm_active) && !$past(cfg_we))
      |-> $stable(to_dram)); // R7
  AST_WIN_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> !wr_blocked); // R7
endmodule

bind legacy_region_decoder legacy_region_decoder_chk #(.ADDR_W(ADDR_W), .DRAM_TOP(DRAM_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .smm_active(smm_active),
  .acc_addr(acc_addr), .acc_write(acc_write), .to_dram(to_dram), .wr_blocked(wr_blocked)
);

// File: tb/sim_legacy_region_decoder.sv
module sim_legacy_region_decoder;
  localparam logic [31:0] TOP = 32'h0800_0000;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, smm_active = 1'b0, acc_write = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic [31:0] acc_addr = 32'h0;
  logic to_dram, wr_blocked;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  legacy_region_decoder #(.ADDR_W(32), .DRAM_TOP(TOP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .smm_active(smm_active), .acc_addr(acc_addr), .acc_write(acc_write),
    .to_dram(to_dram), .wr_blocked(wr_blocked));

  // {addr, write, smm, expected to_dram, expected wr_blocked}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {32'h000F_0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h000F_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h000C_0000, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h000C_4000, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h000C_7FFF, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h000C_8000, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h000C_C000, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h000E_8000, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h000E_C000, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h000D_0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h000A_0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h000B_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0009_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0010_0000, 1'b1, 1'b0, 1'b1, 1'b0},
    {TOP - 32'd1,   1'b0, 1'b0, 1'b1, 1'b0},
    {TOP,           1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:       return "R2/R4";
      2:          return "R3/R4";
      3, 4, 7:    return "R3/R5";
      5, 6, 9:    return "R3/R6";
      8:          return "R3";
      10, 11:     return "R7";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic exp_d, logic exp_b);
    checks++;
    if (to_dram !== exp_d || wr_blocked !== exp_b) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b smm=%0b: actual dram=%0b blk=%0b expected dram=%0b blk=%0b",
               tag, acc_addr, acc_write, smm_active, to_dram, wr_blocked, exp_d, exp_b);
    end
  endtask

  task automatic wr_cfg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(logic [31:0] a, logic w, logic s);
    acc_addr = a; acc_write = w; smm_active = s; #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    access(32'h000F_0000, 1'b1, 1'b0); check("R1", 1'b0, 1'b0);
    access(32'h000C_0000, 1'b0, 1'b0); check("R1", 1'b0, 1'b0);
    access(32'h000E_C000, 1'b1, 1'b0); check("R1", 1'b0, 1'b0);
    access(32'h000A_0000, 1'b0, 1'b1); check("R1", 1'b0, 1'b0);

    // R11 timing: value visible right after the capturing edge
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'h59; cfg_wdata = 8'h30;
    access(32'h000F_0000, 1'b0, 1'b0); check("R11 before edge", 1'b0, 1'b0);
    @(posedge clk); #1; cfg_we = 1'b0;
    check("R11 after edge", 1'b1, 1'b0);

    wr_cfg(8'h5A, 8'h13);
    wr_cfg(8'h5B, 8'h20);
    wr_cfg(8'h5F, 8'h31);
    wr_cfg(8'h72, 8'h08);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][35:4], VEC[i][3], VEC[i][2]);
      check(vec_tag(i), VEC[i][1], VEC[i][0]);
    end

    // R8 mode toggle between edges
    @(posedge clk); #5;
    access(32'h000A_8000, 1'b0, 1'b1); check("R8 smm on", 1'b1, 1'b0);
    access(32'h000A_8000, 1'b0, 1'b0); check("R8 smm off", 1'b0, 1'b0);

    // R7 force-open bit and both bits clear
    wr_cfg(8'h72, 8'h40);
    access(32'h000B_0000, 1'b1, 1'b0); check("R7 force open", 1'b1, 1'b0);
    wr_cfg(8'h72, 8'h00);
    access(32'h000B_0000, 1'b0, 1'b1); check("R7 closed", 1'b0, 1'b0);

    // R10 neighbouring offsets ignored
    wr_cfg(8'h58, 8'hFF);
    wr_cfg(8'h60, 8'hFF);
    wr_cfg(8'h71, 8'hFF);
    access(32'h000C_8000, 1'b1, 1'b0); check("R10", 1'b0, 1'b0);
    access(32'h000D_4000, 1'b0, 1'b0); check("R10", 1'b0, 1'b0);
    access(32'h000A_0000, 1'b0, 1'b1); check("R10", 1'b0, 1'b0);
    access(32'h000F_0000, 1'b1, 1'b0); check("R10", 1'b1, 1'b0);

    // R2 / R5 / R6 other codes on the top region
    wr_cfg(8'h59, 8'h10);
    access(32'h000F_8000, 1'b1, 1'b0); check("R2/R5 write", 1'b1, 1'b1);
    access(32'h000F_8000, 1'b0, 1'b0); check("R2/R5 read", 1'b1, 1'b0);
    wr_cfg(8'h59, 8'h23);
    access(32'h000F_8000, 1'b1, 1'b0); check("R2/R6 code2", 1'b0, 1'b0);

    // R3 odd field of middle byte
    wr_cfg(8'h5C, 8'h30);
    access(32'h000D_4000, 1'b1, 1'b0); check("R3 odd", 1'b1, 1'b0);
    access(32'h000D_0000, 1'b1, 1'b0); check("R3 even", 1'b0, 1'b0);

    finish_run();
  end
endmodule